// File: doc/BRIEF.md
# Three-Way Priority Arbiter with Hold

This block gives one shared resource to at most one of three devices. Each device raises its request line and waits for its own grant line. The arbiter is a Moore state machine with four states: a free state and one ownership state for each device. The grant outputs decode from the state alone, so a grant appears in the clock cycle after the edge that entered the ownership state.

Priority matters only while the resource is free. Device 0 ranks highest and device 2 lowest. After a device has been granted, it keeps the resource for as long as it holds its request high. A higher-ranked request that arrives during that time does not take the resource away. When the owner drops its request, the machine spends one cycle in the free state with no grant, even if other requests are waiting. It arbitrates again on the following edge.

Top module: `tri_hold_arbiter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the machine in the free state. `grant` reads 3'b000 after that edge, whatever the current ownership and requests.
- R2: In the free state, if `req[0]` is high, `grant` becomes 3'b001 after the next edge, whatever the other requests are.
- R3: In the free state, if `req[0]` is low and `req[1]` is high, `grant` becomes 3'b010 after the next edge.
- R4: In the free state, if only `req[2]` is high, `grant` becomes 3'b100 after the next edge.
- R5: In the free state with `req` equal to 3'b000, `grant` stays 3'b000.
- R6: While device k owns the resource (`grant[k]` high) and `req[k]` stays high, `grant` does not change, even if other requests rise.
- R7: When the owner's request is low at an edge, `grant` becomes 3'b000 for at least that next cycle, even if other requests are pending.
- R8: At most one bit of `grant` is high in any cycle.
- R9: `grant` never moves directly from one device to another; every change of owner passes through 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 3 | Request lines; bit 0 has the highest rank and bit 2 the lowest |
| grant | output | 3 | Grant lines, one-hot or zero; bit k is for device k |

## Verification
The assertions assume that `req` and `rst` hold known values at every rising edge, and that reset is high from time zero up to the first edge. Under those conditions the free state can be read at the ports as `grant == 0`. The bench drives every input on the falling edge, so each value is stable when the next rising edge samples it. The bench starts in reset and never leaves an input unknown.

// File: rtl/tri_hold_arbiter.sv
module tri_hold_arbiter (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] req,
  output logic [2:0] grant
);

  typedef enum logic [1:0] {FREE, OWN0, OWN1, OWN2} st_t;

  st_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      FREE: begin
        if (req[0])      st_nx = OWN0;
        else if (req[1]) st_nx = OWN1;
        else if (req[2]) st_nx = OWN2;
        else             st_nx = FREE;
      end
      OWN0: st_nx = req[0] ? OWN0 : FREE;
      OWN1: st_nx = req[1] ? OWN1 : FREE;
      OWN2: st_nx = req[2] ? OWN2 : FREE;
      default: st_nx = FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= FREE;
    else     st <= st_nx;
  end

  assign grant = {st == OWN2, st == OWN1, st == OWN0};

  AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));                                                      // R8
  AST_PICK_TOP: assert property (@(posedge clk) disable iff (rst)
    (grant == 3'b000 && req[0]) |=> grant == 3'b001);                      // R2
  AST_PICK_MID: assert property (@(posedge clk) disable iff (rst)
    (grant == 3'b000 && !req[0] && req[1]) |=> grant == 3'b010);           // R3
  AST_PICK_LOW: assert property (@(posedge clk) disable iff (rst)
    (grant == 3'b000 && req == 3'b100) |=> grant == 3'b100);               // R4
  AST_STAY_FREE: assert property (@(posedge clk) disable iff (rst)
    (grant == 3'b000 && req == 3'b000) |=> grant == 3'b000);               // R5
  AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (rst)
    ((grant & req) != 3'b000) |=> $stable(grant));                         // R6
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (grant != 3'b000 && (grant & req) == 3'b000) |=> grant == 3'b000);     // R7
  AST_VIA_FREE: assert property (@(posedge clk) disable iff (rst)
    (grant != 3'b000) |=> ($stable(grant) || grant == 3'b000));            // R9

endmodule

// File: tb/tri_hold_arbiter_bench.sv
module tri_hold_arbiter_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req = 3'b000;
  logic [2:0] grant;

  typedef struct { logic [2:0] g; string tag; } exp_t;
  exp_t exp_q[$];

  int total = 0;
  int bad = 0;
  int owner = 0;
  logic [2:0] prev_g = 3'b000;
  bit prev_ok = 1'b0;

  tri_hold_arbiter u_tri_hold_arbiter (.clk(clk), .rst(rst), .req(req), .grant(grant));

  always #(PERIOD/2) clk = ~clk;

  task automatic step(input logic r, input logic [2:0] q, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r;
    req = q;
    if (r)                     owner = 0;
    else if (owner == 0)       owner = q[0] ? 1 : q[1] ? 2 : q[2] ? 3 : 0;
    else if (!q[owner-1])      owner = 0;
    e.g = (owner == 0) ? 3'b000 : 3'(1 << (owner - 1));
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (grant !== e.g) begin
        bad++;
        $display("FAIL %s: grant=%b expected=%b", e.tag, grant, e.g);
      end
      total++;
      if ($countones(grant) > 1) begin
        bad++;
        $display("FAIL R8: grant=%b expected at most one bit", grant);
      end
      if (prev_ok) begin
        total++;
        if (prev_g != 3'b000 && grant != 3'b000 && grant != prev_g) begin
          bad++;
          $display("FAIL R9: grant=%b expected %b or 000", grant, prev_g);
        end
      end
      prev_g = grant;
      prev_ok = !rst;
    end
  end

  initial begin
    #(PERIOD * 5000);
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1, 3'b000, "R1");
    step(1, 3'b000, "R1");
    step(0, 3'b000, "R5");
    step(0, 3'b000, "R5");
    step(0, 3'b001, "R2");
    step(0, 3'b111, "R6");
    step(0, 3'b111, "R6");
    step(0, 3'b110, "R7");
    step(0, 3'b110, "R3");
    step(0, 3'b011, "R6");
    step(0, 3'b001, "R7");
    step(0, 3'b000, "R5");
    step(0, 3'b100, "R4");
    step(0, 3'b101, "R6");
    step(0, 3'b111, "R6");
    step(0, 3'b001, "R7");
    step(0, 3'b001, "R2");
    step(1, 3'b001, "R1");
    step(0, 3'b111, "R2");
    step(0, 3'b000, "R7");
    step(0, 3'b110, "R3");
    step(0, 3'b000, "R7");
    step(0, 3'b100, "R4");
    step(0, 3'b100, "R6");
    step(0, 3'b000, "R7");
    step(0, 3'b000, "R5");
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule